// File: doc/BRIEF.md
# Random Word Harvest Controller

This block is a bus master that, on a fixed schedule, pulls a batch of random words out of a hardware random-generator register block and hands them on as one strobed batch. It brings the generator up after reset with a short start sequence. In order, the sequence masks the generator's interrupt, loads its warm-up count and sets its run bit, plus the double-speed bit when that is requested. It then waits a fixed number of seconds, counted in pulses of a tick input, before each harvest.

A harvest polls the generator's status register for the number of words ready. It reads no more data words than are both ready and still needed, and repeats until the batch is full. Polls that find nothing are counted. Each such poll raises a running underrun counter. A run of empty polls that reaches a configurable threshold is taken as a stall. The first stall in a harvest stops the generator and restarts it. A second stall in the same harvest stops it for good and delivers whatever words were already gathered. After that the controller issues no further bus accesses until it is reset.

Top module: `rng_harvester`

## Requirements
- R1: While reset is held no bus request is made. After reset the start sequence runs in this order: read the interrupt-mask register (word address 4) and write it back with bit 0 set; write the warm-up constant to the status register (address 1); read the control register (address 0) and write it back with bit 0 (run) set, bit 1 (double speed) set when `fast_req` is high, and every other bit unchanged.
- R2: The first status poll follows the initial start sequence after exactly TICKS_PER_SEC tick pulses. Each later harvest's first poll follows the previous batch after exactly 4*TICKS_PER_SEC tick pulses.
- R3: A poll is a read of the status register, whose bits [31:24] give the number of ready words. When that number is non-zero, the controller reads the data register (address 2) min(ready, still needed) times before it polls again.
- R4: A completed harvest raises `batch_valid` for exactly one cycle, with `batch_count` equal to 4 and the words in arrival order (word i in bits [32*i+31:32*i]).
- R5: Every poll that returns zero ready words increases `underrun_cnt` by exactly one. Other accesses leave it unchanged.
- R6: When the run of empty polls reaches `stall_thr` for the first time in a harvest, the controller reads the control register and writes it back with bit 0 cleared and other bits kept, runs the start sequence of R1 again, clears the run and resumes polling.
- R7: When the run reaches `stall_thr` a second time in the same harvest, the controller does the same stop write and then delivers the partial batch, with `batch_count` equal to the words gathered. It makes no bus request afterwards.
- R8: A poll that finds words ends the run of empty polls, so only consecutive empty polls count toward a stall.
- R9: Once raised, `bus_req` and its address, direction and write data stay constant until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse, TICKS_PER_SEC pulses per second |
| fast_req | input | 1 | Request double-speed generation at each start sequence |
| stall_thr | input | THR_W | Consecutive empty polls that make a stall |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Word address of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| batch_valid | output | 1 | One-cycle strobe of a delivered batch |
| batch_count | output | CNT_OUT_W | Number of valid words in the batch |
| batch_words | output | WORDS*DATA_W | Collected words, word 0 in the low bits |
| underrun_cnt | output | UNDER_W | Running count of empty polls |

## Verification
Two things can land on the same poll: the underrun count step and the stall decision. The threshold-reaching empty poll must both add one to the counter and turn the controller toward the stop sequence. This is provoked with a threshold of 3 and scripted status replies that give three empty polls in a row, first in a harvest that then recovers and later in one that stalls twice. The bench judges it at the cycle after the acknowledge: the counter must have stepped, and the very next bus access must be the control-register read of the stop sequence, not another poll. A second scripted run (empty, empty, words, empty) checks that a non-empty poll in between keeps the same threshold from firing.

// File: rtl/rng_harvest_pkg.sv
package rng_harvest_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_MASK_RD,
        ST_MASK_WR,
        ST_WARM_WR,
        ST_RUN_RD,
        ST_RUN_WR,
        ST_WAIT,
        ST_POLL,
        ST_FETCH,
        ST_HALT_RD,
        ST_HALT_WR,
        ST_HAND,
        ST_DEAD
    } hst_e;

    localparam int RUN_BIT     = 0;
    localparam int FAST_BIT    = 1;
    localparam int IRQ_OFF_BIT = 0;
    localparam int LEVEL_LSB   = 24;
    localparam int LEVEL_W     = 8;

endpackage

// File: rtl/rng_tick_timer.sv
module rng_tick_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rng_word_collect.sv
module rng_word_collect #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int CNT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [WORDS*DATA_W-1:0] words,
    output logic [CNT_W-1:0]        count
);
    logic [CNT_W-1:0] fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (clr)     fill_d = '0;
        else if (wr) fill_d = fill_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_d, slot_q;
        always_comb begin
            slot_d = slot_q;
            if (wr && !clr && fill_q == CNT_W'(g)) slot_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign words[g*DATA_W +: DATA_W] = slot_q;
    end

    assign count = fill_q;

    assert_slot_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (fill_q < CNT_W'(WORDS)));

endmodule

// File: rtl/rng_harvester.sv
module rng_harvester
    import rng_harvest_pkg::*;
#(
    parameter int          DATA_W        = 32,
    parameter int          ADDR_W        = 4,
    parameter int          WORDS         = 4,
    parameter int          TICKS_PER_SEC = 1000,
    parameter int          FIRST_SECS    = 1,
    parameter int          REST_SECS     = 4,
    parameter int          THR_W         = 8,
    parameter int          UNDER_W       = 16,
    parameter logic [31:0] WARMUP        = 32'h0004_0000,
    parameter int          ADDR_CTRL     = 0,
    parameter int          ADDR_STAT     = 1,
    parameter int          ADDR_DATA     = 2,
    parameter int          ADDR_MASK     = 4,
    localparam int         CNT_OUT_W     = $clog2(WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    fast_req,
    input  logic [THR_W-1:0]        stall_thr,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_ack,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    batch_valid,
    output logic [CNT_OUT_W-1:0]    batch_count,
    output logic [WORDS*DATA_W-1:0] batch_words,
    output logic [UNDER_W-1:0]      underrun_cnt
);
    localparam int          TMR_W     = $clog2(TICKS_PER_SEC * REST_SECS + 1);
    localparam logic [TMR_W-1:0] FIRST_WAIT = TMR_W'(TICKS_PER_SEC * FIRST_SECS);
    localparam logic [TMR_W-1:0] REST_WAIT  = TMR_W'(TICKS_PER_SEC * REST_SECS);
    localparam logic [DATA_W-1:0] RUN_M  = DATA_W'(1) << RUN_BIT;
    localparam logic [DATA_W-1:0] FAST_M = DATA_W'(1) << FAST_BIT;
    localparam logic [DATA_W-1:0] IRQ_M  = DATA_W'(1) << IRQ_OFF_BIT;

    typedef struct packed {
        hst_e                 st;
        logic [DATA_W-1:0]    hold;
        logic [CNT_OUT_W-1:0] need;
        logic [CNT_OUT_W-1:0] burst;
        logic [THR_W-1:0]     empties;
        logic                 stalled;
        logic                 dying;
        logic                 in_harv;
        logic [UNDER_W-1:0]   under;
    } regs_t;

    regs_t r_d, r_q;

    logic              tmr_load, tmr_expired, col_clr, col_wr;
    logic [TMR_W-1:0]  tmr_val;
    logic [LEVEL_W-1:0] level;
    logic [CNT_OUT_W-1:0] take;
    logic [THR_W:0]    empties_nx;

    assign level      = bus_rdata[LEVEL_LSB +: LEVEL_W];
    assign take       = (LEVEL_W'(r_q.need) > level) ? CNT_OUT_W'(level) : r_q.need;
    assign empties_nx = {1'b0, r_q.empties} + (THR_W+1)'(1);

    always_comb begin
        r_d       = r_q;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        tmr_load  = 1'b0;
        tmr_val   = REST_WAIT;
        col_clr   = 1'b0;
        col_wr    = 1'b0;
        unique case (r_q.st)
            ST_BOOT: r_d.st = ST_MASK_RD;
            ST_MASK_RD: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(ADDR_MASK);
                if (bus_ack) begin
                    r_d.hold = bus_rdata;
                    r_d.st   = ST_MASK_WR;
                end
            end
            ST_MASK_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(ADDR_MASK);
                bus_wdata = r_q.hold | IRQ_M;
                if (bus_ack) r_d.st = ST_WARM_WR;
            end
            ST_WARM_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(ADDR_STAT);
                bus_wdata = DATA_W'(WARMUP);
                if (bus_ack) r_d.st = ST_RUN_RD;
            end
            ST_RUN_RD, ST_HALT_RD: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(ADDR_CTRL);
                if (bus_ack) begin
                    r_d.hold = bus_rdata;
                    r_d.st   = (r_q.st == ST_RUN_RD) ? ST_RUN_WR : ST_HALT_WR;
                end
            end
            ST_RUN_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(ADDR_CTRL);
                bus_wdata = r_q.hold | RUN_M | (fast_req ? FAST_M : '0);
                if (bus_ack) begin
                    if (r_q.in_harv) begin
                        r_d.st = ST_POLL;
                    end else begin
                        r_d.st   = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = FIRST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    r_d.st      = ST_POLL;
                    r_d.in_harv = 1'b1;
                    r_d.need    = CNT_OUT_W'(WORDS);
                    r_d.empties = '0;
                    r_d.stalled = 1'b0;
                    col_clr     = 1'b1;
                end
            end
            ST_POLL: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(ADDR_STAT);
                if (bus_ack) begin
                    if (level == '0) begin
                        r_d.under = r_q.under + UNDER_W'(1);
                        if (empties_nx >= {1'b0, stall_thr}) begin
                            r_d.st      = ST_HALT_RD;
                            r_d.dying   = r_q.stalled;
                            r_d.stalled = 1'b1;
                            r_d.empties = '0;
                        end else begin
                            r_d.empties = empties_nx[THR_W-1:0];
                        end
                    end else begin
                        r_d.empties = '0;
                        r_d.burst   = take;
                        r_d.st      = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(ADDR_DATA);
                if (bus_ack) begin
                    col_wr    = 1'b1;
                    r_d.need  = r_q.need - CNT_OUT_W'(1);
                    r_d.burst = r_q.burst - CNT_OUT_W'(1);
                    if (r_q.burst == CNT_OUT_W'(1))
                        r_d.st = (r_q.need == CNT_OUT_W'(1)) ? ST_HAND : ST_POLL;
                end
            end
            ST_HALT_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(ADDR_CTRL);
                bus_wdata = r_q.hold & ~RUN_M;
                if (bus_ack) r_d.st = r_q.dying ? ST_HAND : ST_MASK_RD;
            end
            ST_HAND: begin
                r_d.in_harv = 1'b0;
                if (r_q.dying) begin
                    r_d.st = ST_DEAD;
                end else begin
                    r_d.st   = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = REST_WAIT;
                end
            end
            ST_DEAD: r_d.st = ST_DEAD;
            default: r_d.st = ST_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_BOOT;
        end else begin
            r_q <= r_d;
        end
    end

    rng_tick_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (r_q.st == ST_WAIT),
        .tick     (tick),
        .expired  (tmr_expired)
    );

    rng_word_collect #(.DATA_W(DATA_W), .WORDS(WORDS), .CNT_W(CNT_OUT_W)) u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (col_clr),
        .wr    (col_wr),
        .wdata (bus_rdata),
        .words (batch_words),
        .count (batch_count)
    );

    assign batch_valid  = (r_q.st == ST_HAND);
    assign underrun_cnt = r_q.under;

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    assert_batch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        batch_valid |=> !batch_valid);

    assert_full_batch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (batch_valid && !r_q.dying) |-> (batch_count == CNT_OUT_W'(WORDS)));

    assert_under_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (underrun_cnt == $past(underrun_cnt)
                  || underrun_cnt == $past(underrun_cnt) + UNDER_W'(1)));

    assert_dead_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEAD) |=> (!bus_req && !batch_valid));

endmodule

// File: tb/tb_rng_harvester.sv
module tb_rng_harvester;
    localparam int CLK_PERIOD = 10;
    localparam int TPS   = 5;
    localparam int WORDS = 4;
    localparam int CW    = $clog2(WORDS + 1);
    localparam logic [31:0] WARM = 32'h0004_0000;

    localparam int C_RD_MASK = 0, C_WR_MASK = 1, C_WR_WARM = 2, C_RD_CTRL = 3,
                   C_WR_RUN = 4, C_WR_HALT = 5, C_RD_STAT = 6, C_RD_DATA = 7;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, fast_req = 1'b0;
    logic [7:0] stall_thr = 8'd3;
    logic bus_req, bus_we, bus_ack = 1'b0;
    logic [3:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;
    logic batch_valid;
    logic [CW-1:0] batch_count;
    logic [WORDS*32-1:0] batch_words;
    logic [15:0] underrun_cnt;

    rng_harvester #(.TICKS_PER_SEC(TPS), .WORDS(WORDS), .WARMUP(WARM)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fast_req(fast_req),
        .stall_thr(stall_thr), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .batch_valid(batch_valid),
        .batch_count(batch_count), .batch_words(batch_words),
        .underrun_cnt(underrun_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // slave registers and reference model state
    logic [31:0] ctrl_reg = 32'h0F00_3C00, mask_reg = 32'h0000_0010;
    int exp_q[$];
    int level_q[$] = '{2, 5, 0, 0, 1, 0, 4, 0, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0};
    int m_under = 0, m_under_pend = 0, m_need = 0, m_empties = 0, m_nb = 0;
    int m_batches = 0, word_seq = 0, tick_cnt = 0, tick_snap = 0, wait_n = 0;
    bit m_active = 0, m_dead = 0, m_stalled = 0, m_dying = 0, pend_batch = 0;
    logic [31:0] exp_batch [WORDS];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_start();
        exp_q.push_back(C_RD_MASK); exp_q.push_back(C_WR_MASK);
        exp_q.push_back(C_WR_WARM); exp_q.push_back(C_RD_CTRL);
        exp_q.push_back(C_WR_RUN);
    endtask

    task automatic serve(output bit snap_now);
        int code, lvl, n;
        bit e_we;
        int e_addr;
        logic [31:0] e_wd;
        string tag;
        snap_now = 0;
        if (m_dead) begin
            chk(0, "R7", "bus access after shutdown", bus_addr, 0);
            bus_rdata = '0;
            return;
        end
        if (exp_q.size() == 0) begin
            if (!m_active) begin
                chk(tick_cnt - tick_snap == wait_n, "R2", "ticks before first poll",
                    tick_cnt - tick_snap, wait_n);
                m_active = 1; m_need = WORDS; m_empties = 0; m_stalled = 0; m_nb = 0;
            end
            exp_q.push_back(C_RD_STAT);
        end
        code = exp_q.pop_front();
        e_wd = '0; e_we = 0; e_addr = 0; tag = "R1";
        case (code)
            C_RD_MASK: begin e_addr = 4; end
            C_WR_MASK: begin e_addr = 4; e_we = 1; e_wd = mask_reg | 32'h1; end
            C_WR_WARM: begin e_addr = 1; e_we = 1; e_wd = WARM; end
            C_RD_CTRL: begin e_addr = 0; tag = m_stalled ? "R6" : "R1"; end
            C_WR_RUN:  begin e_addr = 0; e_we = 1;
                             e_wd = ctrl_reg | 32'h1 | (fast_req ? 32'h2 : 32'h0); end
            C_WR_HALT: begin e_addr = 0; e_we = 1; e_wd = ctrl_reg & ~32'h1;
                             tag = m_dying ? "R7" : "R6"; end
            C_RD_STAT: begin e_addr = 1; tag = "R3"; end
            default:   begin e_addr = 2; tag = "R3"; end
        endcase
        chk(bus_we == e_we, tag, "access direction", bus_we, e_we);
        chk(bus_addr == 4'(e_addr), tag, "access address", bus_addr, e_addr);
        if (e_we) chk(bus_wdata == e_wd, tag, "write data", bus_wdata, e_wd);
        // slave reply and register effects
        bus_rdata = 32'h0;
        if (bus_we) begin
            if (bus_addr == 4'd4) mask_reg = bus_wdata;
            if (bus_addr == 4'd0) ctrl_reg = bus_wdata;
        end else begin
            case (bus_addr)
                4'd4: bus_rdata = mask_reg;
                4'd0: bus_rdata = ctrl_reg;
                4'd2: begin bus_rdata = 32'hC0DE_0000 + 32'(word_seq); word_seq++; end
                default: bus_rdata = 32'h0;
            endcase
        end
        // model reaction
        case (code)
            C_WR_RUN: if (!m_active) begin snap_now = 1; wait_n = TPS; end
            C_RD_STAT: begin
                lvl = (level_q.size() != 0) ? level_q.pop_front() : 4;
                bus_rdata = {8'(lvl), 24'h0005A3};
                if (lvl == 0) begin
                    m_under_pend++;
                    m_empties++;
                    if (m_empties >= int'(stall_thr)) begin
                        m_dying = m_stalled; m_stalled = 1; m_empties = 0;
                        exp_q.push_back(C_RD_CTRL); exp_q.push_back(C_WR_HALT);
                        if (!m_dying) push_start();
                    end
                end else begin
                    m_empties = 0;  // R8: a non-empty poll ends the run
                    n = (lvl < m_need) ? lvl : m_need;
                    for (int i = 0; i < n; i++) exp_q.push_back(C_RD_DATA);
                end
            end
            C_RD_DATA: begin
                exp_batch[m_nb] = bus_rdata; m_nb++; m_need--;
                if (m_need == 0) begin pend_batch = 1; m_active = 0; end
            end
            C_WR_HALT: if (m_dying) begin pend_batch = 1; m_active = 0; end
            default: ;
        endcase
        if (exp_q.size() == 0 && m_active && !pend_batch) exp_q.push_back(C_RD_STAT);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // bus slave, tick source and per-cycle comparison
    initial begin
        int cyc = 0;
        bit snap;
        forever begin
            @(negedge clk);
            cyc++;
            snap = 0;
            if (!rst_n) begin
                bus_ack = 1'b0;
            end else if (bus_ack) begin
                bus_ack = 1'b0;
                m_under += m_under_pend; m_under_pend = 0;
                chk(underrun_cnt == 16'(m_under), "R5", "underrun count", underrun_cnt, m_under);
                if (pend_batch) begin
                    pend_batch = 0;
                    m_batches++;
                    chk(batch_valid == 1'b1, m_dying ? "R7" : "R4", "batch strobe", batch_valid, 1);
                    chk(batch_count == CW'(m_nb), m_dying ? "R7" : "R4", "batch count",
                        batch_count, m_nb);
                    for (int i = 0; i < m_nb; i++)
                        chk(batch_words[i*32 +: 32] == exp_batch[i], "R4", "batch word",
                            batch_words[i*32 +: 32], exp_batch[i]);
                    if (m_dying) m_dead = 1;
                    else begin snap = 1; wait_n = 4 * TPS; end
                end else begin
                    chk(batch_valid == 1'b0, "R4", "stray batch strobe", batch_valid, 0);
                end
            end else begin
                chk(batch_valid == 1'b0, "R4", "stray batch strobe", batch_valid, 0);
                chk(underrun_cnt == 16'(m_under), "R5", "underrun idle", underrun_cnt, m_under);
                if (bus_req) begin
                    serve(snap);
                    bus_ack = 1'b1;
                end
            end
            tick = (cyc % 4 == 0);
            if (tick) tick_cnt++;
            if (snap) tick_snap = tick_cnt;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_req == 1'b0, "R1", "request in reset", bus_req, 0);
        chk(underrun_cnt == 16'd0, "R1", "underrun in reset", underrun_cnt, 0);
        chk(batch_valid == 1'b0, "R1", "strobe in reset", batch_valid, 0);
        rst_n = 1'b1;
        push_start();
        wait (m_batches == 1);
        fast_req = 1'b1;
        wait (m_dead);
        repeat (4 * TPS * 4 * 3) @(negedge clk);
        chk(m_batches == 4, "R7", "batches delivered", m_batches, 4);
        chk(m_under == 12, "R5", "total empty polls", m_under, 12);
        chk(bus_req == 1'b0, "R7", "quiet after shutdown", bus_req, 0);
        chk(ctrl_reg[0] == 1'b0, "R7", "run bit left clear", ctrl_reg[0], 0);
        chk(ctrl_reg[31:2] == 30'(32'h0F00_3C00 >> 2), "R6", "other control bits kept",
            ctrl_reg, 32'h0F00_3C00);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        finish_up();
    end

endmodule